// File: doc/BRIEF.md
# Single-Level Trap Entry Sequencer

This block carries out trap entry for a 32-bit processor with windowed registers and one trap level. A trap request arrives on a valid/ready channel with a trap type and the program counter pair at trap time. If traps are enabled and the type is legal, the sequencer first updates the status fields: it rotates the current window pointer down by one, saves the supervisor bit into the previous-supervisor bit, enters supervisor mode and disables traps. It also stamps the trap type into the trap base register. It then stores the trap-time PC and NPC into two local registers of the new window through a register-write port, one per cycle, and finally redirects fetch to the trap vector.

The status fields and the base field of the trap base register can be loaded through a plain control port while the sequencer is idle. The block has no mechanism for choosing among traps, no window-overflow check and no return path. Those belong to neighbouring logic.

A trap that is requested while traps are disabled, or one whose type is 0x100 or above, does not vector. It drives the block into a sticky error state that only reset clears.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset: traps disabled (et=0), supervisor bit 1, previous-supervisor bit 0, window pointer 0, trap base register 0, no error state, trap_ready=1, rf_we=0, redirect=0.
- R2: A request is accepted on a clock edge where trap_valid and trap_ready are both 1. trap_ready is 0 from acceptance until entry completes (two cycles later), and it stays 0 while in error state. A source holding trap_valid while trap_ready is 0 must keep its fields stable.
- R3: On an accepted legal trap with et=1, the window pointer becomes (cwp-1) mod NWINDOWS, so 0 wraps to NWINDOWS-1.
- R4: On the same entry, ps takes the old supervisor bit, the supervisor bit becomes 1, and et becomes 0.
- R5: On entry, tbr[31:12] keeps its base, tbr[11:4] becomes trap_type[7:0], and tbr[3:0] is 0.
- R6: In the first cycle after acceptance, rf_we=1, rf_win is the new window pointer, rf_idx=17 (local register 1 of the window, locals being indices 16..23) and rf_data is the trap-time PC.
- R7: In the second cycle after acceptance, rf_we=1, rf_win is the new window pointer, rf_idx=18 (local register 2) and rf_data is the trap-time NPC.
- R8: In that second cycle redirect=1, pc_out equals the updated tbr and npc_out equals tbr+4. In every other cycle, redirect=0.
- R9: A request accepted with et=0 sets err_state, and err_state holds until reset. No register write, redirect, or change to the status fields or tbr follows.
- R10: Types 0x80 to 0xFF (software traps) vector like any other legal type. A type of 0x100 or above sets err_state exactly as in R9.
- R11: When st_load=1 while idle and no request is accepted, et, the supervisor bit, cwp and tbr[31:12] take st_et, st_s, st_cwp and st_base. tbr[11:0] and ps are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request valid |
| trap_ready | output | 1 | Sequencer can accept a request |
| trap_type | input | 9 | Trap type; 0x100 and above illegal |
| trap_pc | input | 32 | PC at trap time |
| trap_npc | input | 32 | NPC at trap time |
| st_load | input | 1 | Load status fields (idle only) |
| st_et | input | 1 | Trap-enable value to load |
| st_s | input | 1 | Supervisor value to load |
| st_cwp | input | CW | Window pointer to load |
| st_base | input | 20 | Trap base field to load |
| et | output | 1 | Traps enabled |
| s_mode | output | 1 | Supervisor bit |
| ps | output | 1 | Previous supervisor bit |
| cwp | output | CW | Current window pointer |
| tbr | output | 32 | Trap base register |
| err_state | output | 1 | Sticky error state |
| rf_we | output | 1 | Register-file write enable |
| rf_win | output | CW | Window of the write |
| rf_idx | output | 5 | Register index within the window |
| rf_data | output | 32 | Write data |
| redirect | output | 1 | Fetch redirect strobe |
| pc_out | output | 32 | New PC on redirect |
| npc_out | output | 32 | New NPC on redirect |

## Verification
The bench targets the window wrap from 0 to NWINDOWS-1. A design that got this wrong would write the saved PC into a window that does not exist, or into the old window. It checks that ps captures the supervisor bit from before entry: with S cleared first, a design that copied the new value would show ps=1. Requests with traps disabled and with type 0x100 must leave cwp, tbr and the write port untouched; a faulty design would vector or write to the register file. Software-trap types with bit 7 set check that the full eight type bits reach tbr and the vector address.

// File: rtl/trap_pkg.sv
package trap_pkg;
  parameter int XLEN     = 32;
  parameter int TT_W     = 9;
  parameter int IDX_W    = 5;
  parameter int BASE_LSB = 12;
  parameter int BASE_W   = XLEN - BASE_LSB;
  parameter logic [IDX_W-1:0] PC_SLOT  = 5'd17;
  parameter logic [IDX_W-1:0] NPC_SLOT = 5'd18;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PC    = 2'd1,
    SQ_NPC   = 2'd2,
    SQ_FAULT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/trap_win_ctl.sv
module trap_win_ctl #(
  parameter int NWINDOWS = 8,
  localparam int CW = $clog2(NWINDOWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cwp
);
  logic [CW-1:0] cwp_dn;

  generate
    if ((1 << CW) == NWINDOWS) begin : g_pow2
      assign cwp_dn = cwp - 1'b1;
    end else begin : g_mod
      assign cwp_dn = (cwp == '0) ? CW'(NWINDOWS - 1) : cwp - 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    cwp <= '0;
    else if (dec)  cwp <= cwp_dn;
    else if (load) cwp <= load_val;
  end

  // R3
  cwp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (cwp == (($past(cwp) == '0) ? CW'(NWINDOWS - 1) : $past(cwp) - 1'b1)));
endmodule

// File: rtl/trap_base_reg.sv
module trap_base_reg
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BASE_W-1:0] base_in,
  input  logic              set_tt,
  input  logic [7:0]        tt_in,
  output logic [XLEN-1:0]   tbr
);
  logic [BASE_W-1:0] base_q;
  logic [7:0]        tt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      tt_q   <= '0;
    end else if (set_tt) begin
      tt_q   <= tt_in;
    end else if (load) begin
      base_q <= base_in;
    end
  end

  assign tbr = {base_q, tt_q, 4'b0000};

  // R5
  tbr_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_tt |=> (tbr[11:4] == $past(tt_in)) && (tbr[XLEN-1:BASE_LSB] == $past(tbr[XLEN-1:BASE_LSB])));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int NWINDOWS = 8,
  localparam int CW = $clog2(NWINDOWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid,
  output logic              trap_ready,
  input  logic [TT_W-1:0]   trap_type,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_npc,
  input  logic              st_load,
  input  logic              st_et,
  input  logic              st_s,
  input  logic [CW-1:0]     st_cwp,
  input  logic [BASE_W-1:0] st_base,
  output logic              et,
  output logic              s_mode,
  output logic              ps,
  output logic [CW-1:0]     cwp,
  output logic [XLEN-1:0]   tbr,
  output logic              err_state,
  output logic              rf_we,
  output logic [CW-1:0]     rf_win,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [XLEN-1:0]   rf_data,
  output logic              redirect,
  output logic [XLEN-1:0]   pc_out,
  output logic [XLEN-1:0]   npc_out
);
  seq_state_e        state_q, state_d;
  logic [XLEN-1:0]   pc_q, npc_q;
  logic              accept, legal, enter, fault, ld_ok;

  assign trap_ready = (state_q == SQ_IDLE);
  assign accept     = trap_valid && trap_ready;
  assign legal      = (trap_type[TT_W-1:8] == '0);
  assign enter      = accept && et && legal;
  assign fault      = accept && !(et && legal);
  assign ld_ok      = st_load && trap_ready && !accept;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (enter) state_d = SQ_PC; else if (fault) state_d = SQ_FAULT;
      SQ_PC:    state_d = SQ_NPC;
      SQ_NPC:   state_d = SQ_IDLE;
      SQ_FAULT: state_d = SQ_FAULT;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      et      <= 1'b0;
      s_mode  <= 1'b1;
      ps      <= 1'b0;
      pc_q    <= '0;
      npc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (enter) begin
        ps     <= s_mode;
        s_mode <= 1'b1;
        et     <= 1'b0;
        pc_q   <= trap_pc;
        npc_q  <= trap_npc;
      end else if (ld_ok) begin
        et     <= st_et;
        s_mode <= st_s;
      end
    end
  end

  trap_win_ctl #(.NWINDOWS(NWINDOWS)) u_win (
    .clk(clk), .rst_n(rst_n), .load(ld_ok), .load_val(st_cwp),
    .dec(enter), .cwp(cwp)
  );

  trap_base_reg u_tbr (
    .clk(clk), .rst_n(rst_n), .load(ld_ok), .base_in(st_base),
    .set_tt(enter), .tt_in(trap_type[7:0]), .tbr(tbr)
  );

  assign err_state = (state_q == SQ_FAULT);
  assign rf_we     = (state_q == SQ_PC) || (state_q == SQ_NPC);
  assign rf_win    = cwp;
  assign rf_idx    = (state_q == SQ_NPC) ? NPC_SLOT : PC_SLOT;
  assign rf_data   = (state_q == SQ_NPC) ? npc_q : pc_q;
  assign redirect  = (state_q == SQ_NPC);
  assign pc_out    = tbr;
  assign npc_out   = tbr + XLEN'(4);

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> !trap_ready);
  // R4
  flags_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> !et && s_mode && (ps == $past(s_mode)));
  // R8
  redirect_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(rf_we) && (rf_idx == NPC_SLOT));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_state |=> err_state && !rf_we && $stable(cwp) && $stable(tbr));
  // R10
  bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !legal) |=> err_state);
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
  localparam int NW = 8;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_valid = 0, st_load = 0, st_et = 0, st_s = 0;
  logic [8:0] trap_type = '0;
  logic [31:0] trap_pc = '0, trap_npc = '0;
  logic [CW-1:0] st_cwp = '0;
  logic [19:0] st_base = '0;
  logic trap_ready, et, s_mode, ps, err_state, rf_we, redirect;
  logic [CW-1:0] cwp, rf_win;
  logic [31:0] tbr, rf_data, pc_out, npc_out;
  logic [4:0] rf_idx;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  trap_entry_seq #(.NWINDOWS(NW)) u0 (.*);

  function automatic logic [CW-1:0] exp_cwp(input logic [CW-1:0] c);
    return (c == 0) ? CW'(NW - 1) : c - 1'b1;
  endfunction
  function automatic logic [31:0] exp_vec(input logic [19:0] b, input logic [7:0] t);
    return {b, t, 4'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_st(input logic e, input logic s, input logic [CW-1:0] c, input logic [19:0] b);
    @(negedge clk);
    st_load = 1; st_et = e; st_s = s; st_cwp = c; st_base = b;
    @(negedge clk);
    st_load = 0;
  endtask

  // legal trap with traps enabled; full check of the three-cycle entry
  task automatic entry(input logic [7:0] t, input logic [31:0] p, input logic [31:0] n,
                       input logic [CW-1:0] c0, input logic s0, input logic [19:0] b);
    logic [CW-1:0] nc;
    nc = exp_cwp(c0);
    @(negedge clk);
    trap_valid = 1; trap_type = {1'b0, t}; trap_pc = p; trap_npc = n;
    @(negedge clk);
    trap_valid = 0;
    chk("R2 busy", 32'(trap_ready), 32'd0);
    chk("R3 cwp", 32'(cwp), 32'(nc));
    chk("R4 flags", {29'd0, et, s_mode, ps}, {29'd0, 1'b0, 1'b1, s0});
    chk("R5 tbr", tbr, exp_vec(b, t));
    chk("R6 write", {rf_we, 4'(rf_win), rf_idx}, {1'b1, 4'(nc), 5'd17});
    chk("R6 data", rf_data, p);
    chk("R8 no early redirect", 32'(redirect), 32'd0);
    @(negedge clk);
    chk("R7 write", {rf_we, 4'(rf_win), rf_idx}, {1'b1, 4'(nc), 5'd18});
    chk("R7 data", rf_data, n);
    chk("R8 redirect", 32'(redirect), 32'd1);
    chk("R8 pc", pc_out, exp_vec(b, t));
    chk("R8 npc", npc_out, exp_vec(b, t) + 32'd4);
    @(negedge clk);
    chk("R2 ready again", {30'd0, trap_ready, rf_we | redirect}, {30'd0, 1'b1, 1'b0});
  endtask

  task automatic fault_case(input logic [8:0] t, input logic e, input string req);
    logic [CW-1:0] c0;
    logic [31:0] tb0;
    load_st(e, 1'b0, 3'd5, 20'hABCDE);
    @(negedge clk);
    c0 = cwp; tb0 = tbr;
    trap_valid = 1; trap_type = t; trap_pc = 32'h1111_0000; trap_npc = 32'h1111_0004;
    @(negedge clk);
    trap_valid = 0;
    chk({req, " err"}, {30'd0, err_state, trap_ready}, {30'd0, 1'b1, 1'b0});
    for (int i = 0; i < 3; i++) begin
      chk({req, " quiet"}, {29'd0, rf_we, redirect, err_state}, 32'd1);
      chk({req, " state"}, {28'(cwp), 4'(et)}, {28'(c0), 4'(e)});
      chk({req, " tbr"}, tbr, tb0);
      @(negedge clk);
    end
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 flags", {28'd0, et, s_mode, ps, err_state}, {28'd0, 4'b0100});
    chk("R1 cwp/tbr", {29'(cwp), 3'd0} | tbr, 32'd0);
    chk("R1 handshake", {29'd0, trap_ready, rf_we, redirect}, {29'd0, 3'b100});

    // R11: load leaves ps and tbr low bits alone
    load_st(1'b1, 1'b0, 3'd3, 20'h12345);
    chk("R11 load", {28'(cwp), et, s_mode, ps, 1'b0}, {28'd3, 4'b1000});
    chk("R11 tbr", tbr, 32'h1234_5000);

    // R3/R4 directed: wrap from 0, ps takes old S=0
    load_st(1'b1, 1'b0, 3'd0, 20'h00400);
    entry(8'h09, 32'h4000_0100, 32'h4000_0104, 3'd0, 1'b0, 20'h00400);
    // R10 software trap type
    load_st(1'b1, 1'b1, 3'd7, 20'hFFFFF);
    entry(8'hFF, 32'hDEAD_BEE0, 32'hDEAD_BEE4, 3'd7, 1'b1, 20'hFFFFF);
    load_st(1'b1, 1'b0, 3'd4, 20'h00001);
    entry(8'h80, 32'h0, 32'h4, 3'd4, 1'b0, 20'h00001);

    // random entries
    for (int k = 0; k < 40; k++) begin
      logic [CW-1:0] c;
      logic s;
      logic [19:0] b;
      c = CW'($urandom); s = 1'($urandom); b = 20'($urandom);
      load_st(1'b1, s, c, b);
      entry(8'($urandom), $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, c, s, b);
    end

    // R9 / R10 error paths
    fault_case(9'h005, 1'b0, "R9");
    fault_case(9'h100, 1'b1, "R10");
    fault_case(9'h1FF, 1'b1, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule